// File: doc/BRIEF.md
# Ingress Priority Resolver

This block decides the traffic priority of a frame as it enters a switch. The parser upstream gives it a one-cycle strobe with the frame's facts: whether a VLAN tag was present and its 3-bit user priority, whether an IPv4 header was present and its Type-of-Service byte, and the number of the port the frame arrived on. Each port also supplies a default user priority and a ceiling-enable bit.

Two results are produced together, one cycle after the strobe. The first is the 802.1p field to carry forward. When the ceiling is on for the ingress port, a tag priority above that port's default is pulled down to the default. The second is a 2-bit queue priority, taken from a fully decoded Differentiated Services table. The table holds 64 two-bit entries, packed into a 128-bit map and written one byte at a time. Frames without an IP header get no table priority, and a flag marks that result as invalid.

Top module: `ingress_prio_resolver`

## Requirements
- R1: During and right after synchronous active-low reset, `res_valid` and `qprio_valid` are 0, and `res_pcp` and `qprio` are 0. Every map byte reads as 0 after reset.
- R2: `res_valid` is 1 in exactly the cycle after each cycle in which `parse_valid` is 1, and 0 otherwise.
- R3: When `parse_valid` is 0, `res_pcp`, `qprio` and `qprio_valid` keep their values.
- R4: Port p has its default priority at `cfg_def_pcp[3p+2:3p]` and its ceiling enable at `cfg_ceil_en[p]`. For a tagged frame on a port with the ceiling enabled, a tag priority greater than the default gives `res_pcp` equal to the default.
- R5: For a tagged frame on a port with the ceiling enabled, a tag priority less than or equal to the default passes to `res_pcp` unchanged.
- R6: With the ceiling disabled, or for an untagged frame (`tag_present` = 0), `in_pcp` passes to `res_pcp` unchanged.
- R7: The code point is `in_tos[7:2]`. For an IP frame, `qprio` equals bits [2n+1:2n] of the 128-bit map, where n is the code point, and `qprio_valid` is 1.
- R8: A write with `map_wr_en` = 1 loads `map_wr_data` into map byte `map_wr_addr` (16 bytes). Byte k holds code points 4k..4k+3, with code point 4k+j at byte bits [2j+1:2j]. The new value is used for lookups from the next cycle.
- R9: For a non-IP frame (`ip_present` = 0), `qprio_valid` is 0 and `qprio` is 0.
- R10: An ingress port number of `NUM_PORTS` or above never applies the ceiling, so `in_pcp` passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_def_pcp | input | 3*NUM_PORTS | Per-port default user priority, port p at bits [3p+2:3p] |
| cfg_ceil_en | input | NUM_PORTS | Per-port priority-ceiling enable |
| map_wr_en | input | 1 | Map byte write strobe |
| map_wr_addr | input | 4 | Map byte index |
| map_wr_data | input | 8 | Map byte value |
| parse_valid | input | 1 | Frame facts valid this cycle |
| ingress_port | input | PORT_W | Arrival port number |
| tag_present | input | 1 | Frame carried a VLAN tag |
| in_pcp | input | 3 | Tag user priority |
| ip_present | input | 1 | Frame carried an IPv4 header |
| in_tos | input | 8 | Type-of-Service byte |
| res_valid | output | 1 | Results updated this cycle |
| res_pcp | output | 3 | Resolved 802.1p priority |
| qprio | output | 2 | Queue priority from the code-point map |
| qprio_valid | output | 1 | Queue priority is meaningful |

## Verification
The embedded properties check on every cycle that the result strobe follows the parse strobe with a one-cycle lag, that outputs hold between strobes, and that a clamped tag priority never exceeds the port's default. They also check that non-IP frames drop the queue-priority flag and that each map write lands in the addressed byte. Only the bench's scenarios can show that the exact table entry is picked for all 64 code points, and that the packing of entries inside each byte is right. The scenarios also cover the full priority sweep around each port's default and out-of-range port numbers.

// File: rtl/prio_res_pkg.sv
// Shared widths and types for the ingress priority resolver.
// Assumes 802.1p priorities of 3 bits and a 2-bit queue priority per code point.
package prio_res_pkg;
    localparam int PCP_W    = 3;
    localparam int QPRIO_W  = 2;
    localparam int DSCP_W   = 6;
    localparam int TOS_W    = 8;
    localparam int CFG_W    = 8;
    localparam int CODE_PTS = 1 << DSCP_W;
    localparam int MAP_W    = CODE_PTS * QPRIO_W;
    localparam int MAP_REGS = MAP_W / CFG_W;
    localparam int MAP_AW   = $clog2(MAP_REGS);

    typedef logic [PCP_W-1:0]   pcp_t;
    typedef logic [QPRIO_W-1:0] qprio_t;
    typedef logic [DSCP_W-1:0]  dscp_t;
endpackage

// File: rtl/dscp_map_regs.sv
// Code-point map storage: MAP_REGS byte registers written one at a time,
// presented as one packed map. Byte k occupies map bits [8k+7:8k].
// Assumes every address value selects an existing byte.
module dscp_map_regs
    import prio_res_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [MAP_AW-1:0]    wr_addr,
    input  logic [CFG_W-1:0]     wr_data,
    output logic [MAP_W-1:0]     map
);
    logic [CFG_W-1:0] regs [MAP_REGS];

    // Byte register file: clear on reset, load the addressed byte on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAP_REGS; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_addr] <= wr_data;
        end
    end

    // Pack the bytes into the flat map, lowest byte at the bottom.
    for (genvar g = 0; g < MAP_REGS; g++) begin : g_pack
        assign map[g*CFG_W +: CFG_W] = regs[g];
    end

    // R8
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/dscp_lookup.sv
// Combinational selection of one 2-bit queue priority from the packed map.
// Code point n selects map bits [2n+1:2n]. Assumes a full 64-entry map.
module dscp_lookup
    import prio_res_pkg::*;
(
    input  logic [MAP_W-1:0] map,
    input  dscp_t            dscp,
    output qprio_t           prio
);
    // Index the map by code point times entry width.
    always_comb begin
        prio = map[{dscp, 1'b0} +: QPRIO_W];
    end
endmodule

// File: rtl/pcp_ceiling.sv
// Combinational user-priority ceiling: a tagged priority above the
// port default is replaced by the default when the ceiling is enabled.
// Untagged frames and disabled ceilings pass the input through.
module pcp_ceiling
    import prio_res_pkg::*;
(
    input  logic tagged_in,
    input  logic ceil_on,
    input  pcp_t pcp_in,
    input  pcp_t def_pcp,
    output pcp_t pcp_out
);
    // Clamp against the default only for tagged frames with the ceiling on.
    always_comb begin
        if (tagged_in && ceil_on && (pcp_in > def_pcp)) pcp_out = def_pcp;
        else                                           pcp_out = pcp_in;
    end
endmodule

// File: rtl/ingress_prio_resolver.sv
// Ingress priority resolver top. Selects the arriving port's configuration,
// applies the user-priority ceiling, looks up the code-point map and
// registers both results one cycle after parse_valid.
// Assumes port numbers at or above NUM_PORTS carry no configuration.
module ingress_prio_resolver
    import prio_res_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int PORT_W    = $clog2(NUM_PORTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS*PCP_W-1:0]  cfg_def_pcp,
    input  logic [NUM_PORTS-1:0]        cfg_ceil_en,
    input  logic                        map_wr_en,
    input  logic [MAP_AW-1:0]           map_wr_addr,
    input  logic [CFG_W-1:0]            map_wr_data,
    input  logic                        parse_valid,
    input  logic [PORT_W-1:0]           ingress_port,
    input  logic                        tag_present,
    input  logic [PCP_W-1:0]            in_pcp,
    input  logic                        ip_present,
    input  logic [TOS_W-1:0]            in_tos,
    output logic                        res_valid,
    output logic [PCP_W-1:0]            res_pcp,
    output logic [QPRIO_W-1:0]          qprio,
    output logic                        qprio_valid
);
    localparam logic [PORT_W-1:0] LAST_PORT = PORT_W'(NUM_PORTS - 1);

    pcp_t               def_arr [NUM_PORTS];
    logic [MAP_W-1:0]   map;
    pcp_t               sel_def;
    logic               sel_ceil;
    pcp_t               clamped;
    qprio_t             looked_up;
    dscp_t              dscp;
    logic               unused_ecn;

    // Split the packed per-port defaults into an array.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign def_arr[p] = cfg_def_pcp[p*PCP_W +: PCP_W];
    end

    // Pick the arriving port's settings; unknown ports get no ceiling.
    always_comb begin
        sel_def  = '0;
        sel_ceil = 1'b0;
        if (ingress_port <= LAST_PORT) begin
            sel_def  = def_arr[ingress_port];
            sel_ceil = cfg_ceil_en[ingress_port];
        end
    end

    assign dscp       = in_tos[TOS_W-1 -: DSCP_W];
    assign unused_ecn = ^in_tos[TOS_W-DSCP_W-1:0];

    dscp_map_regs u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (map_wr_en),
        .wr_addr (map_wr_addr),
        .wr_data (map_wr_data),
        .map     (map)
    );

    dscp_lookup u_lookup (
        .map  (map),
        .dscp (dscp),
        .prio (looked_up)
    );

    pcp_ceiling u_ceil (
        .tagged_in (tag_present),
        .ceil_on   (sel_ceil),
        .pcp_in    (in_pcp),
        .def_pcp   (sel_def),
        .pcp_out   (clamped)
    );

    // Result strobe: one cycle behind the parse strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) res_valid <= 1'b0;
        else        res_valid <= parse_valid;
    end

    // Result registers: load on the parse strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_pcp     <= '0;
            qprio       <= '0;
            qprio_valid <= 1'b0;
        end else if (parse_valid) begin
            res_pcp     <= clamped;
            qprio       <= ip_present ? looked_up : '0;
            qprio_valid <= ip_present;
        end
    end

    // R2
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        parse_valid |=> res_valid);
    // R2
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !parse_valid |=> !res_valid);
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !parse_valid |=> ($stable(res_pcp) && $stable(qprio) && $stable(qprio_valid)));
    // R4
    ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (parse_valid && tag_present && sel_ceil) |=> (res_pcp <= $past(sel_def)));
    // R9
    non_ip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (parse_valid && !ip_present) |=> (!qprio_valid && qprio == '0));
endmodule

// File: tb/sim_ingress_prio_resolver.sv
`timescale 1ns/1ps
module sim_ingress_prio_resolver;
    localparam int NP = 5;
    localparam int PW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP*3-1:0] cfg_def_pcp = '0;
    logic [NP-1:0]   cfg_ceil_en = '0;
    logic            map_wr_en = 1'b0;
    logic [3:0]      map_wr_addr = '0;
    logic [7:0]      map_wr_data = '0;
    logic            parse_valid = 1'b0;
    logic [PW-1:0]   ingress_port = '0;
    logic            tag_present = 1'b0;
    logic [2:0]      in_pcp = '0;
    logic            ip_present = 1'b0;
    logic [7:0]      in_tos = '0;
    logic            res_valid;
    logic [2:0]      res_pcp;
    logic [1:0]      qprio;
    logic            qprio_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [1:0] exp_map [64];

    always #4 clk = ~clk;

    ingress_prio_resolver #(.NUM_PORTS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_def_pcp(cfg_def_pcp), .cfg_ceil_en(cfg_ceil_en),
        .map_wr_en(map_wr_en), .map_wr_addr(map_wr_addr), .map_wr_data(map_wr_data),
        .parse_valid(parse_valid), .ingress_port(ingress_port), .tag_present(tag_present),
        .in_pcp(in_pcp), .ip_present(ip_present), .in_tos(in_tos),
        .res_valid(res_valid), .res_pcp(res_pcp), .qprio(qprio), .qprio_valid(qprio_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Fill the whole map from a pattern; packing per R8.
    task automatic load_map(input int seed);
        for (int cp = 0; cp < 64; cp++) exp_map[cp] = 2'((cp * 7 + cp / 5 + seed) % 4);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            map_wr_en   = 1'b1;
            map_wr_addr = 4'(k);
            map_wr_data = {exp_map[4*k+3], exp_map[4*k+2], exp_map[4*k+1], exp_map[4*k]};
        end
        @(negedge clk);
        map_wr_en = 1'b0;
    endtask

    // Present one frame, then sample at the following falling edge.
    task automatic send(input bit tg, input int pcp, input bit ip, input int tos, input int port);
        @(negedge clk);
        parse_valid  = 1'b1;
        tag_present  = tg;
        in_pcp       = 3'(pcp);
        ip_present   = ip;
        in_tos       = 8'(tos);
        ingress_port = PW'(port);
        @(negedge clk);
        parse_valid = 1'b0;
        chk(res_valid === 1'b1, "R2 res_valid after strobe", int'(res_valid), 1);
    endtask

    function automatic int exp_pcp(input bit tg, input int pcp, input int port);
        int d;
        if (port >= NP || !tg || !cfg_ceil_en[port]) return pcp;
        d = int'(cfg_def_pcp[port*3 +: 3]);
        return (pcp > d) ? d : pcp;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk(res_valid === 1'b0, "R1 res_valid", int'(res_valid), 0);
        chk(qprio_valid === 1'b0, "R1 qprio_valid", int'(qprio_valid), 0);
        chk(res_pcp === 3'd0, "R1 res_pcp", int'(res_pcp), 0);
        chk(qprio === 2'd0, "R1 qprio", int'(qprio), 0);
        send(1'b0, 0, 1'b1, 8'hFC, 0);
        chk(qprio === 2'd0, "R1 map cleared", int'(qprio), 0);
    endtask

    task automatic t_ceiling();
        cfg_def_pcp = {3'd6, 3'd0, 3'd7, 3'd2, 3'd4};
        cfg_ceil_en = 5'b11111;
        for (int p = 0; p < NP; p++)
            for (int v = 0; v < 8; v++) begin
                send(1'b1, v, 1'b0, 0, p);
                if (v > int'(cfg_def_pcp[p*3 +: 3]))
                    chk(int'(res_pcp) == exp_pcp(1'b1, v, p), "R4 clamp", int'(res_pcp), exp_pcp(1'b1, v, p));
                else
                    chk(int'(res_pcp) == v, "R5 pass below ceiling", int'(res_pcp), v);
            end
    endtask

    task automatic t_passthru();
        cfg_ceil_en = 5'b00000;
        for (int v = 0; v < 8; v++) begin
            send(1'b1, v, 1'b0, 0, 3);
            chk(int'(res_pcp) == v, "R6 ceiling off", int'(res_pcp), v);
        end
        cfg_ceil_en = 5'b11111;
        for (int v = 0; v < 8; v++) begin
            send(1'b0, v, 1'b0, 0, 3);
            chk(int'(res_pcp) == v, "R6 untagged", int'(res_pcp), v);
        end
    endtask

    task automatic t_bad_port();
        cfg_ceil_en = 5'b11111;
        for (int p = NP; p < 8; p++) begin
            send(1'b1, 7, 1'b0, 0, p);
            chk(int'(res_pcp) == 7, "R10 unknown port", int'(res_pcp), 7);
        end
    endtask

    task automatic t_dscp(input int seed);
        load_map(seed);
        for (int cp = 0; cp < 64; cp++) begin
            send(1'b0, 0, 1'b1, (cp << 2) | (cp & 3), 0);
            chk(qprio === exp_map[cp], "R7 R8 map entry", int'(qprio), int'(exp_map[cp]));
            chk(qprio_valid === 1'b1, "R7 valid", int'(qprio_valid), 1);
        end
    endtask

    task automatic t_write_timing();
        // Write byte 5 (code points 20..23), then look up on the next cycle.
        @(negedge clk);
        map_wr_en = 1'b1; map_wr_addr = 4'd5; map_wr_data = 8'b10_01_11_00;
        @(negedge clk);
        map_wr_en = 1'b0;
        parse_valid = 1'b1; tag_present = 1'b0; ip_present = 1'b1; in_tos = 8'(22 << 2);
        @(negedge clk);
        parse_valid = 1'b0;
        chk(qprio === 2'd1, "R8 write visible next cycle", int'(qprio), 1);
    endtask

    task automatic t_non_ip();
        send(1'b0, 0, 1'b1, 22 << 2, 0);
        send(1'b1, 3, 1'b0, 8'hFF, 1);
        chk(qprio_valid === 1'b0, "R9 valid low", int'(qprio_valid), 0);
        chk(qprio === 2'd0, "R9 qprio zero", int'(qprio), 0);
    endtask

    task automatic t_hold();
        send(1'b1, 5, 1'b1, 21 << 2, 4);
        begin
            logic [2:0] hp = res_pcp;
            logic [1:0] hq = qprio;
            in_pcp = 3'd1; in_tos = 8'h00; ip_present = 1'b0; tag_present = 1'b0;
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk(res_valid === 1'b0, "R2 quiet", int'(res_valid), 0);
                chk(res_pcp === hp && qprio === hq && qprio_valid === 1'b1,
                    "R3 hold", int'(res_pcp), int'(hp));
            end
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ceiling();
        t_passthru();
        t_bad_port();
        t_dscp(0);
        t_dscp(3);
        t_write_timing();
        t_non_ip();
        t_hold();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule